// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles using the restoring shift-and-subtract method. A single accumulator holds both the running partial remainder and the quotient that is being built. The upper part of the accumulator takes each trial subtraction. Quotient bits enter the lower part from the right, one bit per cycle. The divisor stays fixed for the whole operation and the accumulator moves past it, so the subtractor is only one bit wider than an operand.

The caller presents a dividend, a divisor and a mode bit, and pulses `start` while the block is idle. The block then stays busy for a fixed number of cycles. When it finishes it raises `done` for one cycle, and the quotient and remainder appear as separate words. In signed mode the block divides the two magnitudes and then corrects the sign of each result. A zero divisor does not stall the block. The operation completes in the normal time and raises a flag.

Top module: `rdiv_core`

## Requirements
- R1: After reset `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: `start` is taken only while `busy` is low. A `start` pulse with other operands while `busy` is high leaves the running operation, its result and its timing unchanged.
- R3: If `start` is taken at clock edge k, `busy` is high from just after edge k until edge k+DATA_W+1. `done` is high for exactly the one cycle after edge k+DATA_W+1, and `busy` is low in that cycle.
- R4: With `sgn_mode`=0 the operands are unsigned over their full range, including a divisor with its MSB set. The block returns quotient = floor(dividend/divisor) and remainder = dividend mod divisor.
- R5: With `sgn_mode`=1 the operands are two's complement and the quotient is the true quotient truncated toward zero. It is negative only when the operand signs differ.
- R6: With `sgn_mode`=1 and a nonzero remainder, the remainder has the sign of the dividend, and dividend = quotient*divisor + remainder.
- R7: A zero divisor in either mode returns a quotient of all ones, a remainder equal to the original dividend and `div_zero`=1, with the same latency as R3. Any later completion with a nonzero divisor returns `div_zero`=0.
- R8: In signed mode the most negative dividend divided by -1 returns the most negative value as the quotient, a remainder of 0 and `div_zero`=0.
- R9: With DATA_W=8, unsigned 73 divided by 5 returns quotient 14 and remainder 3.
- R10: `quotient`, `remainder` and `div_zero` keep their values from one completion to the next, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; taken only when idle |
| sgn_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | DATA_W | Number to be divided |
| divisor | input | DATA_W | Number to divide by |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| quotient | output | DATA_W | Quotient of the last completed division |
| remainder | output | DATA_W | Remainder of the last completed division |
| div_zero | output | 1 | Set when the last completed division had a zero divisor |

## Verification
Every result is due exactly DATA_W+1 clock edges after the edge that takes `start`. The quotient, remainder and flag are first valid in the same cycle that `done` goes high, and `done` falls one edge later. For each operation the bench drives `start` at a falling edge. It then steps through falling edges and checks at each one that `busy` is high and `done` is low. It reads the results only at the falling edge that follows edge k+DATA_W+1, and checks one edge later that `done` has fallen again. The bench sweeps every dividend against a set of edge-case divisors in both modes, and disturbs `start` in the middle of one operation.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIN  = 2'd2
    } rdiv_state_e;

endpackage

// File: rtl/rdiv_operand_prep.sv
module rdiv_operand_prep #(
    parameter int DATA_W = 32
) (
    input  logic              sgn_mode,
    input  logic [DATA_W-1:0] dvd_in,
    input  logic [DATA_W-1:0] dvs_in,
    output logic [DATA_W-1:0] dvd_mag,
    output logic [DATA_W-1:0] dvs_mag,
    output logic              dvd_neg,
    output logic              dvs_neg
);

    always_comb begin
        dvd_neg = sgn_mode & dvd_in[DATA_W-1];
        dvs_neg = sgn_mode & dvs_in[DATA_W-1];
        dvd_mag = dvd_neg ? (~dvd_in + 1'b1) : dvd_in;
        dvs_mag = dvs_neg ? (~dvs_in + 1'b1) : dvs_in;
    end

endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
    parameter int DATA_W = 32,
    localparam int ACC_W = 2 * DATA_W + 1
) (
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [DATA_W-1:0] dvs,
    output logic [ACC_W-1:0]  acc_out,
    output logic              qbit
);

    logic [DATA_W:0]   upper;
    logic [DATA_W+1:0] trial;
    logic [DATA_W-1:0] kept;

    always_comb begin
        upper = acc_in[ACC_W-1:DATA_W];
        trial = {1'b0, upper} - {2'b00, dvs};
        qbit  = ~trial[DATA_W+1];
        // a failed trial keeps the old upper part, so no add-back is needed
        kept  = qbit ? trial[DATA_W-1:0] : upper[DATA_W-1:0];
        acc_out = {kept, acc_in[DATA_W-1:0], qbit};
    end

endmodule

// File: rtl/rdiv_sign_fix.sv
module rdiv_sign_fix #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] q_mag,
    input  logic [DATA_W-1:0] r_mag,
    input  logic              sgn_mode,
    input  logic              dvd_neg,
    input  logic              dvs_neg,
    input  logic              zero_dvs,
    input  logic [DATA_W-1:0] dvd_orig,
    output logic [DATA_W-1:0] q_out,
    output logic [DATA_W-1:0] r_out
);

    logic flip_q;
    logic flip_r;

    always_comb begin
        flip_q = sgn_mode & (dvd_neg ^ dvs_neg);
        flip_r = sgn_mode & dvd_neg;
        if (zero_dvs) begin
            q_out = '1;
            r_out = dvd_orig;
        end else begin
            q_out = flip_q ? (~q_mag + 1'b1) : q_mag;
            r_out = flip_r ? (~r_mag + 1'b1) : r_mag;
        end
    end

endmodule

// File: rtl/rdiv_core.sv
module rdiv_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sgn_mode,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder,
    output logic              div_zero
);
    import rdiv_pkg::*;

    localparam int ACC_W = 2 * DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

    typedef struct packed {
        rdiv_state_e       state;
        logic [ACC_W-1:0]  acc;
        logic [DATA_W-1:0] dvs;
        logic [DATA_W-1:0] dvd;
        logic [CNT_W-1:0]  cnt;
        logic              sgn;
        logic              dvd_neg;
        logic              dvs_neg;
        logic [DATA_W-1:0] quot;
        logic [DATA_W-1:0] rem;
        logic              dz;
        logic              done;
    } rdiv_regs_t;

    rdiv_regs_t r_q, r_d;

    logic [DATA_W-1:0] in_dvd_mag, in_dvs_mag;
    logic              in_dvd_neg, in_dvs_neg;
    logic [ACC_W-1:0]  step_acc;
    logic              step_qbit;
    logic [DATA_W-1:0] fix_q, fix_r;
    logic              zero_dvs;

    rdiv_operand_prep #(.DATA_W(DATA_W)) u_prep (
        .sgn_mode (sgn_mode),
        .dvd_in   (dividend),
        .dvs_in   (divisor),
        .dvd_mag  (in_dvd_mag),
        .dvs_mag  (in_dvs_mag),
        .dvd_neg  (in_dvd_neg),
        .dvs_neg  (in_dvs_neg)
    );

    rdiv_step #(.DATA_W(DATA_W)) u_step (
        .acc_in  (r_q.acc),
        .dvs     (r_q.dvs),
        .acc_out (step_acc),
        .qbit    (step_qbit)
    );

    assign zero_dvs = (r_q.dvs == '0);

    rdiv_sign_fix #(.DATA_W(DATA_W)) u_fix (
        .q_mag    (r_q.acc[DATA_W-1:0]),
        .r_mag    (r_q.acc[ACC_W-1:DATA_W+1]),
        .sgn_mode (r_q.sgn),
        .dvd_neg  (r_q.dvd_neg),
        .dvs_neg  (r_q.dvs_neg),
        .zero_dvs (zero_dvs),
        .dvd_orig (r_q.dvd),
        .q_out    (fix_q),
        .r_out    (fix_r)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state   = ST_ITER;
                    // clear upper part, load magnitude, pre-shift by one
                    r_d.acc     = {{DATA_W{1'b0}}, in_dvd_mag, 1'b0};
                    r_d.dvs     = in_dvs_mag;
                    r_d.dvd     = dividend;
                    r_d.sgn     = sgn_mode;
                    r_d.dvd_neg = in_dvd_neg;
                    r_d.dvs_neg = in_dvs_neg;
                    r_d.cnt     = '0;
                end
            end
            ST_ITER: begin
                r_d.acc = step_acc;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_STEP) begin
                    r_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.quot  = fix_q;
                r_d.rem   = fix_r;
                r_d.dz    = zero_dvs;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign quotient  = r_q.quot;
    assign remainder = r_q.rem;
    assign div_zero  = r_q.dz;

    // ---------------- assertions ----------------
    logic [CNT_W:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           lat_cnt <= '0;
        else if (r_q.state == ST_IDLE && start) lat_cnt <= '0;
        else if (busy)                        lat_cnt <= lat_cnt + 1'b1;
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == (CNT_W + 1)'(DATA_W + 1)));

    assert_ignore_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.dvs) && $stable(r_q.dvd) && $stable(r_q.sgn)));

    assert_urem_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !r_q.sgn) |-> (remainder < r_q.dvs));

    assert_srem_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && r_q.sgn && remainder != '0)
            |-> (remainder[DATA_W-1] == r_q.dvd[DATA_W-1]));

    assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1 && remainder == r_q.dvd));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

endmodule

// File: tb/rdiv_core_tb.sv
module rdiv_core_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn_mode = 1'b0;
    logic [N-1:0] dividend = '0;
    logic [N-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [N-1:0] quotient, remainder;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rdiv_core #(.DATA_W(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sgn_mode  (sgn_mode),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [N-1:0] a, input logic [N-1:0] b, input logic sg,
                         output logic [N-1:0] eq, output logic [N-1:0] er, output logic ez);
        int sa, sb, qi, ri;
        ez = (b == '0);
        if (ez) begin
            eq = '1;
            er = a;
        end else if (!sg) begin
            eq = a / b;
            er = a % b;
        end else begin
            sa = $signed(a);
            sb = $signed(b);
            qi = sa / sb;
            ri = sa % sb;
            eq = qi[N-1:0];
            er = ri[N-1:0];
        end
    endtask

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input logic sg,
                          input bit disturb, input string qtag, input string rtag);
        logic [N-1:0] eq, er;
        logic ez;
        bit lat_ok;
        model(a, b, sg, eq, er, ez);
        @(negedge clk);
        dividend = a; divisor = b; sgn_mode = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat_ok = 1;
        for (int c = 0; c < N + 1; c++) begin
            if (!busy || done) lat_ok = 0;
            if (disturb && c == 2) begin
                start = 1'b1; dividend = ~a; divisor = b ^ 8'h01; sgn_mode = ~sg;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        if (!done || busy) lat_ok = 0;
        chk({qtag, " quotient"}, 32'(quotient), 32'(eq));
        chk({rtag, " remainder"}, 32'(remainder), 32'(er));
        chk("R7 div_zero flag", 32'(div_zero), 32'(ez));
        @(negedge clk);
        if (done) lat_ok = 0;
        chk("R3 busy/done timing", 32'(lat_ok), 32'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] dvs_list [12];
        logic [N-1:0] hq, hr;
        logic hz;
        bit hold_ok;
        dvs_list = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07,
                     8'h55, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 quotient", 32'(quotient), 0);
        chk("R1 remainder", 32'(remainder), 0);
        chk("R1 div_zero", 32'(div_zero), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: worked example
        run_op(8'd73, 8'd5, 1'b0, 0, "R9", "R9");

        // R8: most negative over minus one
        run_op(8'h80, 8'hFF, 1'b1, 0, "R8", "R8");

        // R2: start raised while busy must be ignored
        run_op(8'd200, 8'd7, 1'b0, 1, "R2", "R2");
        run_op(8'hC3, 8'h06, 1'b1, 1, "R2", "R2");

        // R7 then a nonzero divisor clears the flag
        run_op(8'h9A, 8'h00, 1'b1, 0, "R7", "R7");
        run_op(8'h9A, 8'h03, 1'b1, 0, "R5", "R6");

        // R10: outputs hold while inputs wander without start
        hq = quotient; hr = remainder; hz = div_zero;
        hold_ok = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dividend = 8'(i * 37); divisor = 8'(i); sgn_mode = i[0];
            if (quotient !== hq || remainder !== hr || div_zero !== hz) hold_ok = 0;
        end
        chk("R10 results held", 32'(hold_ok), 32'd1);

        // R4 / R5 / R6 / R7 sweep: all dividends against edge-case divisors
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 12; d++) begin
                for (int a = 0; a < 256; a++) begin
                    if (dvs_list[d] == '0)
                        run_op(8'(a), dvs_list[d], m[0], 0, "R7", "R7");
                    else if (m == 0)
                        run_op(8'(a), dvs_list[d], 1'b0, 0, "R4", "R4");
                    else
                        run_op(8'(a), dvs_list[d], 1'b1, 0, "R5", "R6");
                end
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule